// File: doc/BRIEF.md
# Asynchronous Serial Port with Line Polarity Control

This block is a single-channel asynchronous serial port. Software moves bytes through an 8-bit data register and selects framing through a control word. The frame is one start bit, eight data bits with the least significant bit first, an optional parity bit and one stop bit. A 16-bit divider sets the bit rate. The receiver oversamples the line sixteen times per bit and takes each bit at mid-period. The line drivers can invert the transmit output and the receive input separately. A sticky break bit holds the transmit line at the space level.

Writes to the control address change the control settings. Reads from the same address return a status word that combines the error flags, the buffer flags, the live input pin and an echo of the low control bits. The receive error flags are sticky until software clears them with a self-clearing bit in the control word. One interrupt output follows the transmit buffer and another follows the receive buffer. Each has its own enable.

Top module: `async_serial_port`

## Requirements
- R1: After reset the status word reads 0x2100 while the pin idles high: buffer empty (bit 8) set, every other flag clear. The divider reads 0, `serOut` idles high and both interrupts are low.
- R2: Register select 0 is data, 1 is control/status and 2 is the divider. A transmitted frame is a low start bit, data bits 0..7, the optional parity bit and a high stop bit, and each bit lasts 16×(divider+1) clock cycles.
- R3: Control bit 1 enables parity and control bit 0 selects odd parity. The parity bit makes the count of ones across data and parity odd when bit 0 is 1 and even when it is 0. This applies to both directions.
- R4: A received byte is readable at select 0 and sets status bit 7. A read of select 0 clears bit 7.
- R5: A data write clears status bit 8 in the next cycle. The bit stays clear while the shifter is still busy and sets again once the shifter takes the byte. `txIrq` equals bit 8 AND control bit 4.
- R6: `rxIrq` equals status bit 7 AND control bit 5.
- R7: Control bit 2 inverts `serOut` and control bit 3 inverts `serIn`. Status bit 13 shows the raw level on the `serIn` pin.
- R8: Control bit 14 is a sticky break. While it is set, `serOut` holds logic 0 before the polarity inversion is applied, and status bit 14 reads 1.
- R9: Status bit 10 (framing) sets when the stop sample is 0. Status bit 9 (parity) sets on a parity mismatch while parity is enabled. The byte is still delivered.
- R10: Status bit 11 (overrun) sets when a frame completes while bit 7 is set. The new byte is discarded and the held byte is kept.
- R11: Status bit 15 is the OR of bits 11..9. A control write with bit 6 set clears bits 11..9.
- R12: Status bits 4..0 echo control bits 4..0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| busSel | input | 2 | Register select: 0 data, 1 control/status, 2 divider |
| busWr | input | 1 | Write strobe |
| busRd | input | 1 | Read strobe; a data read pops the receive buffer |
| busWdata | input | 16 | Write data |
| busRdata | output | 16 | Combinational read data for the selected register |
| serIn | input | 1 | Serial receive line |
| serOut | output | 1 | Serial transmit line |
| txIrq | output | 1 | Transmit buffer empty interrupt |
| rxIrq | output | 1 | Receive buffer full interrupt |

## Verification
The bound checker enforces several rules on every cycle:
- A data write clears the empty flag on the next cycle.
- The receive interrupt never asserts without a full buffer.
- While break is set, the line sits at the level the inversion bit implies.
- A clear-error write empties every error flag.
- Overrun falls only after such a write.
- The status echo matches the last control write.

Some behaviour appears only in the bench's scenarios:
- Frame timing and bit order on the line.
- Parity values in each sense.
- Input inversion.
- Framing and parity detection on malformed frames.
- The overrun case that discards a byte.

// File: rtl/asp_pkg.sv
package asp_pkg;
  localparam int DATA_W = 8;
  localparam int BUS_W = 16;

  typedef enum logic [1:0] {
    SEL_DATA = 2'd0,
    SEL_CTRL = 2'd1,
    SEL_DIV  = 2'd2,
    SEL_NONE = 2'd3
  } regSel_e;

  // line configuration handed from control to datapath
  typedef struct packed {
    logic parOdd;
    logic parEn;
    logic txInv;
    logic rxInv;
    logic brk;
  } lineCfg_t;

  // strobe from control to datapath
  typedef struct packed {
    logic              txStart;
    logic [DATA_W-1:0] txByte;
  } txCmd_t;

  // events from datapath back to control
  typedef struct packed {
    logic              txBusy;
    logic              rxDone;
    logic [DATA_W-1:0] rxByte;
    logic              parErr;
    logic              frmErr;
  } dpEvt_t;
endpackage

// File: rtl/asp_ctrl.sv
module asp_ctrl
  import asp_pkg::*;
#(
  parameter int DIV_W = 16,
  parameter logic [DIV_W-1:0] DIV_RESET = '0
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [1:0]       busSel,
  input  logic             busWr,
  input  logic             busRd,
  input  logic [BUS_W-1:0] busWdata,
  output logic [BUS_W-1:0] busRdata,
  input  logic             serInRaw,
  output lineCfg_t         cfg,
  output logic [DIV_W-1:0] divider,
  output txCmd_t           cmd,
  input  dpEvt_t           evt,
  output logic             txIrq,
  output logic             rxIrq,
  output logic [BUS_W-1:0] statusWord
);
  logic [5:0]        ctrlBits;
  logic              brkReg;
  logic [DIV_W-1:0]  divReg;
  logic [DATA_W-1:0] txHold, rxData;
  logic              txEmpty, rxFull, peFlag, feFlag, oeFlag;
  logic              wrData, wrCtrl, wrDiv, rdDataStb, clrErr;

  assign wrData    = busWr && (busSel == SEL_DATA);
  assign wrCtrl    = busWr && (busSel == SEL_CTRL);
  assign wrDiv     = busWr && (busSel == SEL_DIV);
  assign rdDataStb = busRd && (busSel == SEL_DATA);
  assign clrErr    = wrCtrl && busWdata[6];

  assign cmd.txStart = !txEmpty && !evt.txBusy;
  assign cmd.txByte  = txHold;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      ctrlBits <= '0;
      brkReg   <= 1'b0;
      divReg   <= DIV_RESET;
      txHold   <= '0;
      rxData   <= '0;
      txEmpty  <= 1'b1;
      rxFull   <= 1'b0;
      peFlag   <= 1'b0;
      feFlag   <= 1'b0;
      oeFlag   <= 1'b0;
    end else begin
      if (wrCtrl) begin
        ctrlBits <= busWdata[5:0];
        brkReg   <= busWdata[14];
      end
      if (wrDiv) divReg <= busWdata[DIV_W-1:0];
      if (wrData) begin
        txHold  <= busWdata[DATA_W-1:0];
        txEmpty <= 1'b0;
      end else if (cmd.txStart) begin
        txEmpty <= 1'b1;
      end
      if (evt.rxDone) begin
        peFlag <= peFlag | evt.parErr;
        feFlag <= feFlag | evt.frmErr;
        if (rxFull && !rdDataStb) begin
          oeFlag <= 1'b1;
        end else begin
          rxData <= evt.rxByte;
          rxFull <= 1'b1;
        end
      end else if (rdDataStb) begin
        rxFull <= 1'b0;
      end
      if (clrErr) begin
        peFlag <= 1'b0;
        feFlag <= 1'b0;
        oeFlag <= 1'b0;
      end
    end
  end

  assign cfg.parOdd = ctrlBits[0];
  assign cfg.parEn  = ctrlBits[1];
  assign cfg.txInv  = ctrlBits[2];
  assign cfg.rxInv  = ctrlBits[3];
  assign cfg.brk    = brkReg;
  assign divider    = divReg;

  assign txIrq = txEmpty & ctrlBits[4];
  assign rxIrq = rxFull & ctrlBits[5];

  assign statusWord = {peFlag | feFlag | oeFlag, brkReg, serInRaw, 1'b0,
                       oeFlag, feFlag, peFlag, txEmpty, rxFull, 2'b00,
                       ctrlBits[4:0]};

  always_comb begin
    unique case (busSel)
      SEL_DATA: busRdata = {{(BUS_W-DATA_W){1'b0}}, rxData};
      SEL_CTRL: busRdata = statusWord;
      SEL_DIV:  busRdata = BUS_W'(divReg);
      default:  busRdata = '0;
    endcase
  end
endmodule

// File: rtl/asp_datapath.sv
module asp_datapath
  import asp_pkg::*;
#(
  parameter int DIV_W = 16,
  parameter int OVS = 16
) (
  input  logic             clk,
  input  logic             rstN,
  input  lineCfg_t         cfg,
  input  logic [DIV_W-1:0] divider,
  input  txCmd_t           cmd,
  output dpEvt_t           evt,
  input  logic             serIn,
  output logic             serOut
);
  localparam int SUB_W = $clog2(OVS);
  localparam logic [SUB_W-1:0] SUB_MID  = SUB_W'(OVS/2 - 1);
  localparam logic [SUB_W-1:0] SUB_LAST = SUB_W'(OVS - 1);
  localparam int FRAME_W = DATA_W + 3;
  localparam int IDX_W = $clog2(FRAME_W + 1);

  // oversample tick generator
  logic [DIV_W-1:0] divCnt;
  logic tick;
  assign tick = (divCnt >= divider);
  always_ff @(posedge clk) begin
    if (!rstN) divCnt <= '0;
    else       divCnt <= tick ? '0 : divCnt + 1'b1;
  end

  // transmitter
  logic [FRAME_W-1:0] txShift;
  logic [IDX_W-1:0]   txBits;
  logic [SUB_W-1:0]   txSub;
  logic               txBusy, txPar;
  assign txPar = (^cmd.txByte) ^ cfg.parOdd;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      txShift <= '1;
      txBits  <= '0;
      txSub   <= '0;
      txBusy  <= 1'b0;
    end else if (cmd.txStart) begin
      txShift <= {1'b1, cfg.parEn ? txPar : 1'b1, cmd.txByte, 1'b0};
      txBits  <= cfg.parEn ? IDX_W'(FRAME_W) : IDX_W'(FRAME_W - 1);
      txSub   <= '0;
      txBusy  <= 1'b1;
    end else if (txBusy && tick) begin
      txSub <= txSub + 1'b1;
      if (txSub == SUB_LAST) begin
        txShift <= {1'b1, txShift[FRAME_W-1:1]};
        txBits  <= txBits - 1'b1;
        if (txBits == IDX_W'(1)) txBusy <= 1'b0;
      end
    end
  end

  assign serOut = (cfg.brk ? 1'b0 : (txBusy ? txShift[0] : 1'b1)) ^ cfg.txInv;

  // receiver
  logic [1:0]        inSync;
  logic              rxBit, rxAct, rxPar, rxDone, parErr, frmErr;
  logic [SUB_W-1:0]  rxSub;
  logic [IDX_W-1:0]  rxIdx, stopIdx;
  logic [DATA_W-1:0] rxShift;
  assign rxBit   = inSync[1] ^ cfg.rxInv;
  assign stopIdx = cfg.parEn ? IDX_W'(DATA_W + 2) : IDX_W'(DATA_W + 1);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      inSync  <= 2'b11;
      rxAct   <= 1'b0;
      rxSub   <= '0;
      rxIdx   <= '0;
      rxShift <= '0;
      rxPar   <= 1'b0;
      rxDone  <= 1'b0;
      parErr  <= 1'b0;
      frmErr  <= 1'b0;
    end else begin
      inSync <= {inSync[0], serIn};
      rxDone <= 1'b0;
      if (!rxAct) begin
        if (tick && !rxBit) begin
          rxAct <= 1'b1;
          rxSub <= '0;
          rxIdx <= '0;
        end
      end else if (tick) begin
        rxSub <= rxSub + 1'b1;
        if (rxSub == SUB_MID) begin
          if (rxIdx == '0) begin
            if (rxBit) rxAct <= 1'b0;
          end else if (rxIdx <= IDX_W'(DATA_W)) begin
            rxShift <= {rxBit, rxShift[DATA_W-1:1]};
          end else if (rxIdx == stopIdx) begin
            rxAct  <= 1'b0;
            rxDone <= 1'b1;
            frmErr <= !rxBit;
            parErr <= cfg.parEn && (rxPar != ((^rxShift) ^ cfg.parOdd));
          end else begin
            rxPar <= rxBit;
          end
        end
        if (rxSub == SUB_LAST) rxIdx <= rxIdx + 1'b1;
      end
    end
  end

  assign evt.txBusy = txBusy;
  assign evt.rxDone = rxDone;
  assign evt.rxByte = rxShift;
  assign evt.parErr = parErr;
  assign evt.frmErr = frmErr;
endmodule

// File: rtl/async_serial_port.sv
module async_serial_port
  import asp_pkg::*;
#(
  parameter int DIV_W = 16,
  parameter int OVS = 16
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic [1:0]  busSel,
  input  logic        busWr,
  input  logic        busRd,
  input  logic [15:0] busWdata,
  output logic [15:0] busRdata,
  input  logic        serIn,
  output logic        serOut,
  output logic        txIrq,
  output logic        rxIrq
);
  lineCfg_t         cfg;
  txCmd_t           cmd;
  dpEvt_t           evt;
  logic [DIV_W-1:0] divider;
  logic [15:0]      statusWord;

  asp_ctrl #(.DIV_W(DIV_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .busSel(busSel), .busWr(busWr), .busRd(busRd),
    .busWdata(busWdata), .busRdata(busRdata), .serInRaw(serIn), .cfg(cfg),
    .divider(divider), .cmd(cmd), .evt(evt), .txIrq(txIrq), .rxIrq(rxIrq),
    .statusWord(statusWord)
  );

  asp_datapath #(.DIV_W(DIV_W), .OVS(OVS)) u_dp (
    .clk(clk), .rstN(rstN), .cfg(cfg), .divider(divider), .cmd(cmd),
    .evt(evt), .serIn(serIn), .serOut(serOut)
  );
endmodule

// File: rtl/asp_checker.sv
module asp_checker (
  input logic        clk,
  input logic        rstN,
  input logic [1:0]  busSel,
  input logic        busWr,
  input logic [15:0] busWdata,
  input logic [15:0] statusWord,
  input logic        serOut,
  input logic        rxIrq
);
  p_tbe_clear_r5: assert property (@(posedge clk) disable iff (!rstN)
    (busWr && busSel == 2'd0) |=> !statusWord[8]);

  p_rxirq_full_r6: assert property (@(posedge clk) disable iff (!rstN)
    rxIrq |-> statusWord[7]);

  p_break_level_r8: assert property (@(posedge clk) disable iff (!rstN)
    statusWord[14] |-> (serOut == statusWord[2]));

  p_clear_err_r11: assert property (@(posedge clk) disable iff (!rstN)
    (busWr && busSel == 2'd1 && busWdata[6]) |=>
      (statusWord[11:9] == 3'b000 && !statusWord[15]));

  p_overrun_sticky_r10: assert property (@(posedge clk) disable iff (!rstN)
    $fell(statusWord[11]) |-> $past(busWr && busSel == 2'd1 && busWdata[6]));

  p_echo_r12: assert property (@(posedge clk) disable iff (!rstN)
    (busWr && busSel == 2'd1) |=> (statusWord[4:0] == $past(busWdata[4:0])));
endmodule

bind async_serial_port asp_checker u_chk (
  .clk(clk), .rstN(rstN), .busSel(busSel), .busWr(busWr), .busWdata(busWdata),
  .statusWord(statusWord), .serOut(serOut), .rxIrq(rxIrq)
);

// File: tb/test_async_serial_port.sv
module test_async_serial_port;
  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic        rstN, busWr, busRd, serIn;
  logic [1:0]  busSel;
  logic [15:0] busWdata;
  wire  [15:0] busRdata;
  wire         serOut, txIrq, rxIrq;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;
  int bitCyc = 32;
  bit monEn = 1'b0, monPol = 1'b0, monPar = 1'b0, monOdd = 1'b0;
  logic [7:0] txq[$];
  logic [15:0] st, rd;

  async_serial_port i_async_serial_port (
    .clk(clk), .rstN(rstN), .busSel(busSel), .busWr(busWr), .busRd(busRd),
    .busWdata(busWdata), .busRdata(busRdata), .serIn(serIn), .serOut(serOut),
    .txIrq(txIrq), .rxIrq(rxIrq)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic wrReg(input logic [1:0] s, input logic [15:0] d);
    @(negedge clk);
    busSel = s; busWdata = d; busWr = 1'b1;
    @(negedge clk);
    busWr = 1'b0;
  endtask

  task automatic rdNow(input logic [1:0] s, output logic [15:0] d);
    busSel = s;
    #1 d = busRdata;
  endtask

  task automatic rdPop(output logic [15:0] d);
    @(negedge clk);
    busSel = 2'd0; busRd = 1'b1;
    #1 d = busRdata;
    @(negedge clk);
    busRd = 1'b0;
  endtask

  // driver: push expected byte then write it
  task automatic sendTx(input logic [7:0] b);
    txq.push_back(b);
    wrReg(2'd0, {8'h00, b});
  endtask

  task automatic waitTx();
    while (txq.size() != 0) @(negedge clk);
    repeat (bitCyc) @(negedge clk);
  endtask

  task automatic driveBit(input logic b, input bit inv);
    serIn = b ^ inv;
    repeat (bitCyc) @(negedge clk);
  endtask

  task automatic sendRx(input logic [7:0] d, input bit par, input bit odd,
                        input bit badPar, input bit badStop, input bit inv);
    @(negedge clk);
    driveBit(1'b0, inv);
    for (int i = 0; i < 8; i++) driveBit(d[i], inv);
    if (par) driveBit((^d) ^ odd ^ badPar, inv);
    if (badStop) begin
      serIn = inv;
      repeat (bitCyc * 3 / 4) @(negedge clk);
      serIn = ~inv;
      repeat (bitCyc / 4) @(negedge clk);
    end else begin
      driveBit(1'b1, inv);
    end
    repeat (bitCyc) @(negedge clk);
  endtask

  // monitor: decode frames on serOut and compare with the scoreboard queue
  initial begin
    logic [7:0] got, exp;
    logic p, stopBit;
    forever begin
      @(negedge clk);
      if (monEn && ((serOut ^ monPol) == 1'b0)) begin
        repeat (bitCyc / 2) @(negedge clk);
        for (int i = 0; i < 8; i++) begin
          repeat (bitCyc) @(negedge clk);
          got[i] = serOut ^ monPol;
        end
        p = 1'b0;
        if (monPar) begin
          repeat (bitCyc) @(negedge clk);
          p = serOut ^ monPol;
        end
        repeat (bitCyc) @(negedge clk);
        stopBit = serOut ^ monPol;
        if (txq.size() == 0) begin
          check(1'b0, "R2 unexpected frame", int'(got), 0);
        end else begin
          exp = txq.pop_front();
          check(got == exp, "R2 data bits", int'(got), int'(exp));
          check(stopBit == 1'b1, "R2 stop bit", int'(stopBit), 1);
          if (monPar) check(p == ((^exp) ^ monOdd), "R3 tx parity", int'(p), int'((^exp) ^ monOdd));
        end
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual 0x%0h expected 0x%0h", 0, 1);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    rstN = 1'b0; busSel = 2'd0; busWr = 1'b0; busRd = 1'b0; busWdata = '0; serIn = 1'b1;
    repeat (5) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);

    // R1 reset state
    rdNow(2'd1, st);
    check(st == 16'h2100, "R1 status", int'(st), 16'h2100);
    check(serOut && !txIrq && !rxIrq, "R1 line and irqs", int'({serOut, txIrq, rxIrq}), 4);
    rdNow(2'd2, rd);
    check(rd == 16'h0000, "R1 divider", int'(rd), 0);

    // R2 divider and basic transmit
    wrReg(2'd2, 16'h0001);
    rdNow(2'd2, rd);
    check(rd == 16'h0001, "R2 divider readback", int'(rd), 1);
    monEn = 1'b1;
    sendTx(8'hA5);
    rdNow(2'd1, st);
    check(st[8] == 1'b0, "R5 empty cleared by write", int'(st[8]), 0);
    sendTx(8'h3C);
    repeat (100) @(negedge clk);
    rdNow(2'd1, st);
    check(st[8] == 1'b0, "R5 empty held while shifter busy", int'(st[8]), 0);
    waitTx();
    rdNow(2'd1, st);
    check(st[8] == 1'b1, "R5 empty after drain", int'(st[8]), 1);

    // R3 even then odd parity
    wrReg(2'd1, 16'h0002); monPar = 1'b1;
    sendTx(8'h3C); sendTx(8'h07);
    waitTx();
    wrReg(2'd1, 16'h0003); monOdd = 1'b1;
    sendTx(8'h01); sendTx(8'hFF);
    waitTx();

    // R5 transmit interrupt
    wrReg(2'd1, 16'h0010); monPar = 1'b0; monOdd = 1'b0;
    check(txIrq == 1'b1, "R5 txIrq with empty", int'(txIrq), 1);
    sendTx(8'h81);
    check(txIrq == 1'b0, "R5 txIrq after write", int'(txIrq), 0);
    waitTx();
    check(txIrq == 1'b1, "R5 txIrq after send", int'(txIrq), 1);

    // R7 output inversion
    monEn = 1'b0;
    wrReg(2'd1, 16'h0004);
    monPol = 1'b1; monEn = 1'b1;
    check(serOut == 1'b0, "R7 inverted idle", int'(serOut), 0);
    sendTx(8'h5A);
    waitTx();

    // R8 break
    monEn = 1'b0;
    wrReg(2'd1, 16'h4000);
    check(serOut == 1'b0, "R8 break level", int'(serOut), 0);
    repeat (200) @(negedge clk);
    rdNow(2'd1, st);
    check(serOut == 1'b0 && st[14], "R8 break sticky", int'({serOut, st[14]}), 1);
    wrReg(2'd1, 16'h4004);
    check(serOut == 1'b1, "R8 break inverted", int'(serOut), 1);
    wrReg(2'd1, 16'h0000);
    rdNow(2'd1, st);
    check(serOut == 1'b1 && !st[14], "R8 break released", int'({serOut, st[14]}), 2);
    monPol = 1'b0;

    // R4 / R6 receive
    wrReg(2'd1, 16'h0020);
    check(rxIrq == 1'b0, "R6 rxIrq idle", int'(rxIrq), 0);
    sendRx(8'h96, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0);
    rdNow(2'd1, st);
    check(st[7] == 1'b1, "R4 full set", int'(st[7]), 1);
    check(rxIrq == 1'b1, "R6 rxIrq full", int'(rxIrq), 1);
    rdPop(rd);
    check(rd == 16'h0096, "R4 received byte", int'(rd), 16'h96);
    rdNow(2'd1, st);
    check(st[7] == 1'b0, "R4 full cleared by read", int'(st[7]), 0);
    check(rxIrq == 1'b0, "R6 rxIrq cleared", int'(rxIrq), 0);

    // R7 input inversion and raw pin
    serIn = 1'b0;
    wrReg(2'd1, 16'h0008);
    repeat (bitCyc) @(negedge clk);
    rdNow(2'd1, st);
    check(st[13] == 1'b0, "R7 raw pin level", int'(st[13]), 0);
    sendRx(8'h4B, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1);
    rdPop(rd);
    check(rd == 16'h004B, "R7 inverted receive", int'(rd), 16'h4B);
    serIn = 1'b1;
    wrReg(2'd1, 16'h0000);
    repeat (bitCyc) @(negedge clk);

    // R9 framing error, R11 summary and clear
    sendRx(8'h33, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0);
    rdNow(2'd1, st);
    check(st[10] == 1'b1, "R9 framing flag", int'(st[10]), 1);
    check(st[15] == 1'b1, "R11 summary set", int'(st[15]), 1);
    rdPop(rd);
    check(rd == 16'h0033, "R9 byte kept on framing error", int'(rd), 16'h33);
    wrReg(2'd1, 16'h0040);
    rdNow(2'd1, st);
    check((st & 16'h8E00) == 16'h0000, "R11 cleared", int'(st), 0);

    // R9 parity error
    wrReg(2'd1, 16'h0002);
    sendRx(8'h55, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0);
    rdNow(2'd1, st);
    check(st[9] == 1'b1 && st[10] == 1'b0, "R9 parity flag", int'(st[10:9]), 1);
    rdPop(rd);
    wrReg(2'd1, 16'h0043);
    sendRx(8'h6E, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0);
    rdNow(2'd1, st);
    check(st[9] == 1'b0, "R3 odd parity accepted", int'(st[9]), 0);
    rdPop(rd);
    check(rd == 16'h006E, "R3 odd parity byte", int'(rd), 16'h6E);

    // R10 overrun
    wrReg(2'd1, 16'h0000);
    sendRx(8'h11, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0);
    sendRx(8'h22, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0);
    rdNow(2'd1, st);
    check(st[11] && st[15], "R10 overrun flag", int'({st[15], st[11]}), 3);
    rdPop(rd);
    check(rd == 16'h0011, "R10 old byte kept", int'(rd), 16'h11);
    rdNow(2'd1, st);
    check(st[7] == 1'b0, "R10 new byte discarded", int'(st[7]), 0);
    wrReg(2'd1, 16'h0040);
    rdNow(2'd1, st);
    check(st[11] == 1'b0, "R11 overrun cleared", int'(st[11]), 0);

    // R12 echo
    wrReg(2'd1, 16'h0017);
    rdNow(2'd1, st);
    check(st[4:0] == 5'h17, "R12 control echo", int'(st[4:0]), 16'h17);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule